// File: doc/BRIEF.md
# Bitplane Fetch Slot Sequencer

This block decides, cycle by cycle, which bitplane owns each memory cycle of a raster line's fetch window. The window is built from repeated fetch units of eight memory cycles. Inside each unit, every cycle position belongs to a fixed plane according to one interleaved pattern per resolution. A cycle whose plane is not enabled is left unrequested, so other bus masters can take it.

A one-cycle start pulse opens the window. The sequencer captures the resolution, the enabled plane count and the scroll flag at that moment. It then walks 20 fetch units, or 21 units when scrolling is on, and emits a registered request strobe together with the plane number for every owned cycle. Plane pointers, pixel shifters and bus arbitration lie outside this block.

Top module: `bpf_slot_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `fetch_req` is 0 and `fetch_plane` is 0.
- R2: Suppose `win_start` is sampled high at a clock edge E while no window is running. Slot 0 of the window then appears on the outputs after edge E+1, and slot s appears after edge E+1+s. Without scrolling the window is 160 cycles long. Outside the window `fetch_req` and `fetch_plane` are both 0.
- R3: With `scroll_en` high at the start, the window is 21 units, which is 168 cycles.
- R4: In low resolution (`hires`=0), cycle positions 0 to 7 of a unit are owned by: none, plane 4, plane 6, plane 2, none, plane 3, plane 5, plane 1. `fetch_plane` gives the owning plane as a binary number from 1 to 6.
- R5: In high resolution (`hires`=1), cycle positions 0 to 7 are owned by planes 4, 2, 3, 1, 4, 2, 3, 1.
- R6: A cycle requests only when its owning plane number is at most the enabled plane count. Whenever `fetch_req` is 0, `fetch_plane` is 0.
- R7: A plane count of 0 gives no requests. In low resolution a count above 6 acts as 6. In high resolution a count above 4 acts as 4.
- R8: The mode, the plane count and the scroll flag are captured at the start of the window. Changes to them during the window, and further `win_start` pulses during the window, have no effect on that window.
- R9: Over one window, each enabled plane is requested 20 times in low resolution and 40 times in high resolution. Each count is one unit's worth higher with scrolling: 21 and 42.
- R10: In low resolution with 4 or fewer planes, the even cycle positions (0, 2, 4, 6) never request.
- R11: In high resolution with 4 planes, every cycle of the window requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| hires | input | 1 | Resolution select, 1 = high resolution |
| plane_cnt | input | 3 | Number of enabled bitplanes |
| scroll_en | input | 1 | Adds one extra fetch unit to the line |
| win_start | input | 1 | Pulse that opens the fetch window |
| fetch_req | output | 1 | Registered fetch request for this cycle |
| fetch_plane | output | 3 | Plane owning this cycle (1 to 6), 0 when no request |

## Verification
Some properties are checked by assertions on every cycle:
- outputs stay idle outside the window;
- the plane number stays within the captured count, and is zero whenever there is no request;
- the free low-resolution positions never request;
- a full four-plane high-resolution window requests on every cycle;
- the captured configuration holds steady until the window ends.

Other behaviour can only be shown by the bench's scenarios:
- the exact plane at each position;
- the window length and its one-cycle latency;
- the per-plane word totals with and without scrolling;
- the clamping of out-of-range counts;
- that a mid-window change or restart pulse is ignored.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

    localparam int UNIT_LEN   = 8;
    localparam int SLOT_W     = $clog2(UNIT_LEN);
    localparam int PLANE_W    = 3;
    localparam int LORES_MAX  = 6;
    localparam int HIRES_MAX  = 4;

    typedef enum logic {
        RES_LO = 1'b0,
        RES_HI = 1'b1
    } res_e;

    typedef logic [PLANE_W-1:0] plane_t;
    typedef logic [SLOT_W-1:0]  slot_t;

    typedef struct packed {
        res_e   res;
        plane_t planes;
        logic   scroll;
    } line_cfg_t;

    typedef struct packed {
        logic   req;
        plane_t plane;
    } fetch_t;

    // Owner of each cycle position in a low-resolution unit, 0 = free
    function automatic plane_t lores_owner(slot_t s);
        plane_t p;
        case (s)
            3'd1:    p = 3'd4;
            3'd2:    p = 3'd6;
            3'd3:    p = 3'd2;
            3'd5:    p = 3'd3;
            3'd6:    p = 3'd5;
            3'd7:    p = 3'd1;
            default: p = 3'd0;
        endcase
        return p;
    endfunction

    // Owner of each cycle position in a high-resolution unit
    function automatic plane_t hires_owner(slot_t s);
        plane_t p;
        case (s)
            3'd0, 3'd4: p = 3'd4;
            3'd1, 3'd5: p = 3'd2;
            3'd2, 3'd6: p = 3'd3;
            default:    p = 3'd1;
        endcase
        return p;
    endfunction

    function automatic plane_t clamp_planes(res_e r, plane_t n);
        plane_t lim;
        lim = (r == RES_HI) ? plane_t'(HIRES_MAX) : plane_t'(LORES_MAX);
        return (n > lim) ? lim : n;
    endfunction

endpackage

// File: rtl/bpf_cfg_latch.sv
module bpf_cfg_latch
    import bpf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      hires_in,
    input  plane_t    planes_in,
    input  logic      scroll_in,
    output line_cfg_t cfg_o
);

    line_cfg_t cfg_q;
    res_e      res_in;

    assign res_in = hires_in ? RES_HI : RES_LO;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{res: RES_LO, planes: '0, scroll: 1'b0};
        end else if (load) begin
            cfg_q.res    <= res_in;
            cfg_q.planes <= clamp_planes(res_in, planes_in);
            cfg_q.scroll <= scroll_in;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/bpf_window_ctr.sv
module bpf_window_ctr
    import bpf_pkg::*;
#(
    parameter int BASE_UNITS  = 20,
    parameter int EXTRA_UNITS = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  scroll,
    output logic  active,
    output slot_t slot,
    output logic  last
);

    localparam int LAST_BASE = BASE_UNITS * UNIT_LEN - 1;
    localparam int LAST_SCR  = (BASE_UNITS + EXTRA_UNITS) * UNIT_LEN - 1;
    localparam int POS_W     = $clog2(LAST_SCR + 1);

    logic             active_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pos_q    <= '0;
            limit_q  <= '0;
        end else if (start && !active_q) begin
            active_q <= 1'b1;
            pos_q    <= '0;
            limit_q  <= scroll ? POS_W'(LAST_SCR) : POS_W'(LAST_BASE);
        end else if (active_q) begin
            if (pos_q == limit_q) begin
                active_q <= 1'b0;
                pos_q    <= '0;
            end else begin
                pos_q    <= pos_q + 1'b1;
            end
        end
    end

    assign active = active_q;
    assign slot   = pos_q[SLOT_W-1:0];
    assign last   = active_q && (pos_q == limit_q);

endmodule

// File: rtl/bpf_slot_decode.sv
module bpf_slot_decode
    import bpf_pkg::*;
(
    input  logic      active,
    input  slot_t     slot,
    input  line_cfg_t cfg,
    output fetch_t    fetch
);

    plane_t lo_tab [UNIT_LEN];
    plane_t hi_tab [UNIT_LEN];
    plane_t owner;

    genvar g;
    generate
        for (g = 0; g < UNIT_LEN; g++) begin : g_tab
            assign lo_tab[g] = lores_owner(slot_t'(g));
            assign hi_tab[g] = hires_owner(slot_t'(g));
        end
    endgenerate

    always_comb begin
        owner = (cfg.res == RES_HI) ? hi_tab[slot] : lo_tab[slot];
        fetch = '0;
        if (active && owner != '0 && owner <= cfg.planes) begin
            fetch.req   = 1'b1;
            fetch.plane = owner;
        end
    end

endmodule

// File: rtl/bpf_slot_seq.sv
module bpf_slot_seq
    import bpf_pkg::*;
#(
    parameter int BASE_UNITS  = 20,
    parameter int EXTRA_UNITS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hires,
    input  logic [2:0] plane_cnt,
    input  logic       scroll_en,
    input  logic       win_start,
    output logic       fetch_req,
    output logic [2:0] fetch_plane
);

    logic      start_ok;
    logic      win_active;
    logic      win_last;
    slot_t     slot;
    line_cfg_t cfg;
    fetch_t    dec_fetch;
    fetch_t    fetch_q;

    assign start_ok = win_start && !win_active;

    bpf_cfg_latch u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (start_ok),
        .hires_in  (hires),
        .planes_in (plane_cnt),
        .scroll_in (scroll_en),
        .cfg_o     (cfg)
    );

    bpf_window_ctr #(
        .BASE_UNITS  (BASE_UNITS),
        .EXTRA_UNITS (EXTRA_UNITS)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .start  (start_ok),
        .scroll (scroll_en),
        .active (win_active),
        .slot   (slot),
        .last   (win_last)
    );

    bpf_slot_decode u_dec (
        .active (win_active),
        .slot   (slot),
        .cfg    (cfg),
        .fetch  (dec_fetch)
    );

    always_ff @(posedge clk) begin
        if (rst) fetch_q <= '0;
        else     fetch_q <= dec_fetch;
    end

    assign fetch_req   = fetch_q.req;
    assign fetch_plane = fetch_q.plane;

endmodule

// File: rtl/bpf_slot_seq_chk.sv
module bpf_slot_seq_chk
    import bpf_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      win_start,
    input logic      fetch_req,
    input plane_t    fetch_plane,
    input logic      win_active,
    input logic      win_last,
    input slot_t     slot,
    input line_cfg_t cfg
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!fetch_req && fetch_plane == '0)); // R1

    AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !win_active |=> (!fetch_req && fetch_plane == '0)); // R2

    AST_IDLE_PLANE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |-> fetch_plane == '0); // R6

    AST_PLANE_WITHIN_COUNT: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (fetch_plane != '0 && fetch_plane <= cfg.planes)); // R6

    AST_HI_PLANE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && cfg.res == RES_HI) |-> fetch_plane <= plane_t'(HIRES_MAX)); // R7

    AST_LO_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (win_active && cfg.res == RES_LO && (slot == 3'd0 || slot == 3'd4))
        |=> !fetch_req); // R4

    AST_LO_CPU_SLOTS: assert property (@(posedge clk) disable iff (rst)
        (win_active && cfg.res == RES_LO && cfg.planes <= 3'd4 && !slot[0])
        |=> !fetch_req); // R10

    AST_HI_FULL: assert property (@(posedge clk) disable iff (rst)
        (win_active && cfg.res == RES_HI && cfg.planes == 3'd4) |=> fetch_req); // R11

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (win_active && !win_last) |=> $stable(cfg)); // R8

    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (win_active && !win_last && win_start) |=> win_active); // R8

endmodule

bind bpf_slot_seq bpf_slot_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .win_start   (win_start),
    .fetch_req   (fetch_req),
    .fetch_plane (fetch_plane),
    .win_active  (win_active),
    .win_last    (win_last),
    .slot        (slot),
    .cfg         (cfg)
);

// File: tb/bpf_slot_seq_tb.sv
`timescale 1ns/1ps
module bpf_slot_seq_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       hires;
    logic [2:0] plane_cnt;
    logic       scroll_en;
    logic       win_start;
    logic       fetch_req;
    logic [2:0] fetch_plane;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bpf_slot_seq u_dut (
        .clk         (clk),
        .rst         (rst),
        .hires       (hires),
        .plane_cnt   (plane_cnt),
        .scroll_en   (scroll_en),
        .win_start   (win_start),
        .fetch_req   (fetch_req),
        .fetch_plane (fetch_plane)
    );

    // Reference owner of a cycle position, from the ordering requirements
    function automatic int ref_owner(bit hi, int pos);
        int lo_ord [8] = '{0, 4, 6, 2, 0, 3, 5, 1};
        int hi_ord [4] = '{4, 2, 3, 1};
        return hi ? hi_ord[pos % 4] : lo_ord[pos % 8];
    endfunction

    function automatic int ref_limit(bit hi, int n);
        int mx = hi ? 4 : 6;
        return (n > mx) ? mx : n;
    endfunction

    function automatic int ref_plane(bit hi, int n, int pos);
        int o = ref_owner(hi, pos);
        return (o != 0 && o <= ref_limit(hi, n)) ? o : 0;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Runs one window; disturb changes inputs and pulses start mid-window
    task automatic run_window(bit hi, int n, bit scr, bit disturb, string tag);
        int total = scr ? 168 : 160;
        int cnt [7];
        foreach (cnt[i]) cnt[i] = 0;
        @(negedge clk);
        hires = hi; plane_cnt = 3'(n); scroll_en = scr; win_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        win_start = 1'b0;
        check("R2", {31'd0, fetch_req}, 0, "idle one cycle after start edge");
        for (int s = 0; s < total + 3; s++) begin
            @(posedge clk);
            @(negedge clk);
            if (s < total) begin
                int ep = ref_plane(hi, n, s);
                check(tag, {29'd0, fetch_plane}, ep, $sformatf("plane at cycle %0d", s));
                check(tag, {31'd0, fetch_req}, (ep != 0) ? 1 : 0,
                      $sformatf("request at cycle %0d", s));
                if (fetch_req) cnt[fetch_plane]++;
            end else begin
                check(scr ? "R3" : "R2", {31'd0, fetch_req}, 0,
                      $sformatf("request after window end %0d", s));
                check(scr ? "R3" : "R2", {29'd0, fetch_plane}, 0,
                      $sformatf("plane after window end %0d", s));
            end
            if (disturb) begin
                if (s == 50) begin
                    hires = ~hi; plane_cnt = 3'd5; scroll_en = ~scr; win_start = 1'b1;
                end else if (s == 51) begin
                    win_start = 1'b0;
                end
            end
        end
        for (int p = 1; p <= 6; p++) begin
            int exp_n = (p <= ref_limit(hi, n)) ? (hi ? 2 : 1) * (scr ? 21 : 20) : 0;
            check("R9", cnt[p], exp_n, $sformatf("words for plane %0d", p));
        end
    endtask

    initial begin
        void'($urandom(32'd20240));
        rst = 1'b1; hires = 1'b0; plane_cnt = 3'd0; scroll_en = 1'b0; win_start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {31'd0, fetch_req}, 0, "request during reset");
        check("R1", {29'd0, fetch_plane}, 0, "plane during reset");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", {31'd0, fetch_req}, 0, "request after reset");

        run_window(1'b0, 6, 1'b0, 1'b0, "R4");
        run_window(1'b1, 4, 1'b0, 1'b0, "R11");
        run_window(1'b0, 6, 1'b1, 1'b0, "R3");
        run_window(1'b1, 2, 1'b1, 1'b0, "R5");
        run_window(1'b0, 3, 1'b0, 1'b0, "R10");
        run_window(1'b0, 4, 1'b0, 1'b0, "R10");
        run_window(1'b0, 2, 1'b0, 1'b0, "R6");
        run_window(1'b0, 0, 1'b0, 1'b0, "R7");
        run_window(1'b0, 7, 1'b0, 1'b0, "R7");
        run_window(1'b1, 6, 1'b1, 1'b0, "R7");
        run_window(1'b0, 5, 1'b0, 1'b1, "R8");
        run_window(1'b1, 3, 1'b0, 1'b1, "R8");

        for (int k = 0; k < 24; k++) begin
            bit hi  = 1'($urandom);
            int n   = int'($urandom_range(1, hi ? 4 : 6));
            bit scr = 1'($urandom);
            repeat (int'($urandom_range(0, 4))) @(posedge clk);
            run_window(hi, n, scr, 1'($urandom_range(0, 3) == 0), hi ? "R5" : "R4");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule